// File: doc/BRIEF.md
# Promotable Fixed-Priority Interrupt Arbiter

This block picks one winner among fifteen maskable interrupt requests. Each request line has its own local enable, and one global mask bit blocks all of them at once. When no promotion applies, the winner follows a fixed order. Index 0 has the highest priority and index 14 the lowest.

The order by index is:

| Index | Source |
|---|---|
| 0 | external request |
| 1 | periodic real-time tick |
| 2, 3, 4 | capture channels 1, 2 and 3 |
| 5, 6, 7, 8 | compare channels 1 to 4 |
| 9 | shared capture-4/compare-5 channel |
| 10 | timer wrap |
| 11 | pulse-counter wrap |
| 12 | pulse-counter edge |
| 13 | SPI transfer done |
| 14 | serial communications |

A 4-bit promotion code, held in a register, can lift any single source above all the others. The remaining sources keep their default relative order. Software can change the code only while the global mask is set, so the order never shifts under a live interrupt.

The outputs are recomputed combinationally in every cycle from the current inputs and the stored code. They are a pending flag, the index of the winning source, and that source's fixed vector number. A processor core samples these outputs when it decides whether to take an interrupt and where to fetch its handler.

Top module: `promo_intc`

## Requirements
- R1: With no promotion in effect, the pending winner is the lowest-indexed source whose request and local enable are both high.
- R2: A promotion code c in 1..15 places source c-1 above all other sources, and the remaining sources keep their default relative order.
- R3: After reset the promotion code is 4'b0101, which promotes source index 4 (capture channel 3).
- R4: Promotion code 4'b0000 selects no source and leaves the default order in force.
- R5: While gmask is 1, irq_pending is 0, and irq_idx and irq_vec are both 0. These three outputs are also 0 whenever no enabled request is asserted.
- R6: A promoted source whose local enable is 0 cannot win, and the next eligible source in default order wins instead.
- R7: When a source wins, irq_vec equals VEC_BASE plus that source's index, whether or not the source is promoted.
- R8: A write on sel_wr loads sel_wdata into the promotion code at the rising clock edge only if gmask is 1 at that edge. A write made while gmask is 0 leaves the code unchanged.
- R9: irq_pending, irq_idx and irq_vec follow input changes within the same cycle, and the promotion code in use is the one stored at the last clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 15 | Request lines, index 0 = highest default priority |
| irq_en | input | 15 | Local enable, one bit per source |
| gmask | input | 1 | Global mask; 1 blocks all requests and unlocks code writes |
| sel_wr | input | 1 | Promotion-code write strobe |
| sel_wdata | input | 4 | Promotion-code write value |
| irq_pending | output | 1 | An unmasked, enabled request exists |
| irq_idx | output | 4 | Index of the winning source |
| irq_vec | output | 8 | Vector number of the winning source |

## Verification
The hardest case to reach from the ports is a write made while the global mask is clear. Such a write changes nothing that can be seen at once, because the stored code shows up only through a later arbitration.

The bench first sets a known promotion while the mask is set. It then issues the rejected write with a different value, and afterwards raises every request and enable. The winner at that point shows which code the register still holds.

Random cycles mix writes with a randomly toggling mask. They also use sparse request patterns, so that the promoted source is often absent or disabled and the fall-back to default order is exercised.

// File: rtl/promo_intc_pkg.sv
package promo_intc_pkg;

    localparam int NSRC  = 15;
    localparam int IDX_W = $clog2(NSRC);
    localparam int SEL_W = 4;
    localparam logic [SEL_W-1:0] SEL_RST = 4'b0101;

endpackage

// File: rtl/promo_sel_reg.sv
module promo_sel_reg #(
    parameter int               SEL_W   = 4,
    parameter logic [SEL_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gmask,
    input  logic             wr,
    input  logic [SEL_W-1:0] wdata,
    output logic [SEL_W-1:0] sel
);

    logic wr_ok;

    // Writes land only while the global mask holds interrupts off.
    assign wr_ok = wr & gmask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel <= RST_VAL;
        end else if (wr_ok) begin
            sel <= wdata;
        end
    end

endmodule

// File: rtl/promo_arbiter.sv
module promo_arbiter #(
    parameter int NSRC  = 15,
    parameter int IDX_W = 4,
    parameter int SEL_W = 4
) (
    input  logic [NSRC-1:0]  req,
    input  logic [NSRC-1:0]  en,
    input  logic             gmask,
    input  logic [SEL_W-1:0] sel,
    output logic             pending,
    output logic [IDX_W-1:0] idx
);

    logic [NSRC-1:0]  act;
    logic [NSRC-1:0]  promo_oh;
    logic [NSRC-1:0]  promo_act;
    logic [IDX_W-1:0] def_idx;
    logic [IDX_W-1:0] pro_idx;

    assign act = req & en & {NSRC{~gmask}};

    // Code g+1 promotes source g; code 0 matches no source.
    for (genvar g = 0; g < NSRC; g++) begin : g_decode
        assign promo_oh[g] = (sel == SEL_W'(g + 1));
    end

    assign promo_act = act & promo_oh;

    always_comb begin
        def_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (act[i]) def_idx = IDX_W'(i);
        end
    end

    always_comb begin
        pro_idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (promo_act[i]) pro_idx = IDX_W'(i);
        end
    end

    assign pending = |act;

    always_comb begin
        if (|promo_act) begin
            idx = pro_idx;
        end else if (|act) begin
            idx = def_idx;
        end else begin
            idx = '0;
        end
    end

endmodule

// File: rtl/promo_vec_map.sv
module promo_vec_map #(
    parameter int               IDX_W    = 4,
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h10
) (
    input  logic             pending,
    input  logic [IDX_W-1:0] idx,
    output logic [VEC_W-1:0] vec
);

    // The vector depends only on source identity, not on the source's rank.
    assign vec = pending ? (VEC_BASE + VEC_W'(idx)) : '0;

endmodule

// File: rtl/promo_intc.sv
module promo_intc
    import promo_intc_pkg::*;
#(
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_req,
    input  logic [NSRC-1:0]   irq_en,
    input  logic              gmask,
    input  logic              sel_wr,
    input  logic [SEL_W-1:0]  sel_wdata,
    output logic              irq_pending,
    output logic [IDX_W-1:0]  irq_idx,
    output logic [VEC_W-1:0]  irq_vec
);

    logic [SEL_W-1:0] sel_code;

    promo_sel_reg #(
        .SEL_W   (SEL_W),
        .RST_VAL (SEL_RST)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .gmask (gmask),
        .wr    (sel_wr),
        .wdata (sel_wdata),
        .sel   (sel_code)
    );

    promo_arbiter #(
        .NSRC  (NSRC),
        .IDX_W (IDX_W),
        .SEL_W (SEL_W)
    ) u_arb (
        .req     (irq_req),
        .en      (irq_en),
        .gmask   (gmask),
        .sel     (sel_code),
        .pending (irq_pending),
        .idx     (irq_idx)
    );

    promo_vec_map #(
        .IDX_W    (IDX_W),
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE)
    ) u_vec (
        .pending (irq_pending),
        .idx     (irq_idx),
        .vec     (irq_vec)
    );

endmodule

// File: rtl/promo_intc_chk.sv
module promo_intc_chk
    import promo_intc_pkg::*;
#(
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  irq_req,
    input logic [NSRC-1:0]  irq_en,
    input logic             gmask,
    input logic             sel_wr,
    input logic [SEL_W-1:0] sel_wdata,
    input logic [SEL_W-1:0] sel_code,
    input logic             irq_pending,
    input logic [IDX_W-1:0] irq_idx,
    input logic [VEC_W-1:0] irq_vec
);

    logic [IDX_W-1:0] pro_src;
    logic             pro_live;

    assign pro_src  = IDX_W'(sel_code - SEL_W'(1));
    assign pro_live = (sel_code != '0) && irq_req[pro_src] && irq_en[pro_src];

    a_r3_reset_code: assert property (@(posedge clk)
        !rst_n |=> (sel_code == SEL_RST));

    a_r5_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        gmask |-> (!irq_pending && irq_idx == '0 && irq_vec == '0));

    a_r6_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> (irq_req[irq_idx] && irq_en[irq_idx]));

    a_r2_promoted_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!gmask && pro_live) |-> (irq_pending && irq_idx == pro_src));

    a_r7_vector_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> (irq_vec == VEC_BASE + VEC_W'(irq_idx)));

    a_r8_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && !gmask) |=> $stable(sel_code));

    a_r8_open_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && gmask) |=> (sel_code == $past(sel_wdata)));

endmodule

bind promo_intc promo_intc_chk #(
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .irq_en      (irq_en),
    .gmask       (gmask),
    .sel_wr      (sel_wr),
    .sel_wdata   (sel_wdata),
    .sel_code    (sel_code),
    .irq_pending (irq_pending),
    .irq_idx     (irq_idx),
    .irq_vec     (irq_vec)
);

// File: tb/promo_intc_tb.sv
`timescale 1ns/1ps
module promo_intc_tb;

    localparam int N    = 15;
    localparam int BASE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] irq_req = '0;
    logic [14:0] irq_en = '0;
    logic        gmask = 1'b1;
    logic        sel_wr = 1'b0;
    logic [3:0]  sel_wdata = '0;
    logic        irq_pending;
    logic [3:0]  irq_idx;
    logic [7:0]  irq_vec;

    int n_run = 0;
    int n_fail = 0;
    int m_sel = 5;

    always #2 clk = ~clk;

    promo_intc u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req     (irq_req),
        .irq_en      (irq_en),
        .gmask       (gmask),
        .sel_wr      (sel_wr),
        .sel_wdata   (sel_wdata),
        .irq_pending (irq_pending),
        .irq_idx     (irq_idx),
        .irq_vec     (irq_vec)
    );

    // Reference copy of the promotion code (R3, R8).
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_sel = 5;
        else if (sel_wr && gmask) m_sel = int'(sel_wdata);
    end

    function automatic void ref_arb(input logic [14:0] r, input logic [14:0] e,
                                    input logic m, input int s,
                                    output logic p, output int w);
        p = 1'b0;
        w = 0;
        if (m) return;
        if (s >= 1 && r[s-1] && e[s-1]) begin
            p = 1'b1;
            w = s - 1;
            return;
        end
        for (int k = 0; k < N; k++) begin
            if (r[k] && e[k]) begin
                p = 1'b1;
                w = k;
                return;
            end
        end
    endfunction

    task automatic check(input string tag);
        logic p;
        int   w;
        int   v;
        ref_arb(irq_req, irq_en, gmask, m_sel, p, w);
        v = p ? BASE + w : 0;
        n_run++;
        if (irq_pending !== p || int'(irq_idx) != w || int'(irq_vec) != v) begin
            n_fail++;
            $display("FAIL %s: pend/idx/vec got %0b/%0d/%0d expected %0b/%0d/%0d",
                     tag, irq_pending, irq_idx, irq_vec, p, w, v);
        end
    endtask

    task automatic expect_idx(input string tag, input logic p, input int w);
        n_run++;
        if (irq_pending !== p || int'(irq_idx) != w) begin
            n_fail++;
            $display("FAIL %s: pend/idx got %0b/%0d expected %0b/%0d",
                     tag, irq_pending, irq_idx, p, w);
        end
    endtask

    task automatic drive(input logic [14:0] r, input logic [14:0] e, input logic m,
                         input logic wr, input logic [3:0] wd);
        irq_req   = r;
        irq_en    = e;
        gmask     = m;
        sel_wr    = wr;
        sel_wdata = wd;
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset code promotes index 4
        drive('1, '1, 1'b0, 1'b0, 4'd0);
        step("R3");
        expect_idx("R3", 1'b1, 4);

        // R4: code 0 while masked, then default order
        drive('0, '0, 1'b1, 1'b1, 4'd0);
        step("R5");
        drive(15'h0088, '1, 1'b0, 1'b0, 4'd0);
        step("R4");
        expect_idx("R1", 1'b1, 3);
        drive(15'h6000, '1, 1'b0, 1'b0, 4'd0);
        step("R1");
        expect_idx("R1", 1'b1, 13);

        // R2: code 12 promotes index 11
        drive('0, '0, 1'b1, 1'b1, 4'd12);
        step("R8");
        drive(15'h0801, '1, 1'b0, 1'b0, 4'd0);
        step("R2");
        expect_idx("R2", 1'b1, 11);
        drive(15'h0024, '1, 1'b0, 1'b0, 4'd0);
        step("R2");
        expect_idx("R2", 1'b1, 2);

        // R7: same vector whether promoted or not
        drive(15'h0800, '1, 1'b0, 1'b0, 4'd0);
        step("R7");
        n_run++;
        if (int'(irq_vec) != BASE + 11) begin
            n_fail++;
            $display("FAIL R7: vec got %0d expected %0d", irq_vec, BASE + 11);
        end

        // R6: promoted source disabled
        drive(15'h0801, 15'h77FF, 1'b0, 1'b0, 4'd0);
        step("R6");
        expect_idx("R6", 1'b1, 0);

        // R5: global mask blocks even the promoted source
        drive('1, '1, 1'b1, 1'b0, 4'd0);
        step("R5");
        expect_idx("R5", 1'b0, 0);

        // R8: write while unmasked is ignored
        drive('0, '1, 1'b0, 1'b1, 4'd1);
        step("R8");
        drive('1, '1, 1'b0, 1'b0, 4'd0);
        step("R8");
        expect_idx("R8", 1'b1, 11);

        // R9: outputs follow inputs within the cycle
        drive(15'h0800, '1, 1'b0, 1'b0, 4'd0);
        #1;
        check("R9");
        drive(15'h4000, '1, 1'b0, 1'b0, 4'd0);
        #1;
        check("R9");

        // Random mix, compared on every clock (R1, R2, R6, R8)
        for (int c = 0; c < 3000; c++) begin
            logic [14:0] r;
            logic [14:0] e;
            r = 15'($urandom) & 15'($urandom);
            e = 15'($urandom) | 15'($urandom);
            drive(r, e, ($urandom % 4) == 0, ($urandom % 6) == 0, 4'($urandom));
            step("R2");
        end

        drive('0, '0, 1'b1, 1'b0, 4'd0);
        step("R5");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule